// File: doc/BRIEF.md
# Burst Address Sequencer

This block produces the address sequence for a four-beat burst. A load strobe captures a full base address and the ordering mode. Each advance strobe then steps to the next beat. Only the lowest two address bits move; all higher bits hold the loaded value for the whole burst.

Two orderings are available. Linear ordering counts the low bits upward modulo four, starting from the base value. Interleaved ordering XORs the base low bits with a beat counter that runs 0,1,2,3. After the fourth beat the sequence wraps back to the base address.

Bursting is optional. A caller that loads a fresh address every cycle gets plain single accesses. The block does not decide whether an access is a read or a write, and it drives no memory.

Top module: `burst_seq`

## Requirements
- R1: While rst_ni is low, and after reset until the first load, addr_o and beat_o are zero.
- R2: A clock edge with load_i high makes addr_o equal the addr_i sampled at that edge, and makes beat_o zero, from that edge on.
- R3: With linear ordering loaded (mode_i = 1 at the load), the low two bits of addr_o on beat k are (base low bits + k) mod 4.
- R4: With interleaved ordering loaded (mode_i = 0 at the load), the low two bits of addr_o on beat k are base low bits XOR k.
- R5: Each edge with adv_i high and load_i low steps beat_o by one modulo 4. The fifth and later advances repeat the sequence, so the fourth advance returns addr_o to the base address.
- R6: Address bits above bit 1 change only on a load.
- R7: mode_i is sampled only at a load. Changing it during a burst leaves the sequence unchanged.
- R8: Loading on every cycle gives single accesses: addr_o follows each new addr_i and beat_o stays zero.
- R9: An edge with both load_i and adv_i low leaves addr_o and beat_o unchanged.
- R10: When load_i and adv_i are both high, the load wins. addr_o becomes addr_i and beat_o becomes zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| load_i | input | 1 | Capture addr_i and mode_i, restart at beat 0 |
| adv_i | input | 1 | Step to the next beat |
| mode_i | input | 1 | 1 = linear, 0 = interleaved (tie low when unused) |
| addr_i | input | ADDR_W | Base address |
| addr_o | output | ADDR_W | Current burst address |
| beat_o | output | 2 | Current beat index |

## Verification
Both outputs come from registers, so the effect of a load or an advance first appears after the clock edge that samples it, with no further delay. The bench drives inputs on the falling edge. It then checks the outputs a quarter period after the next rising edge, which is exactly one edge after the stimulus. Every base value is swept in both modes with seven advances, which covers the wrap. The expected values are computed arithmetically from the loaded base and the number of advances since the load.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;
  typedef enum logic {
    ORD_INTLV  = 1'b0,
    ORD_LINEAR = 1'b1
  } burst_order_e;
endpackage

// File: rtl/burst_beat_ctr.sv
module burst_beat_ctr #(
  parameter int BEAT_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              inc_i,
  output logic [BEAT_W-1:0] cnt_o
);
  logic [BEAT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else if (inc_i) cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;

  p_wrap_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && !clr_i && cnt_o == {BEAT_W{1'b1}}) |=> cnt_o == '0);
  p_clear_wins_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> cnt_o == '0);
endmodule

// File: rtl/burst_low_gen.sv
module burst_low_gen
  import burst_seq_pkg::*;
#(
  parameter int BEAT_W = 2
) (
  input  burst_order_e      order_i,
  input  logic [BEAT_W-1:0] base_lo_i,
  input  logic [BEAT_W-1:0] beat_i,
  output logic [BEAT_W-1:0] low_o
);
  always_comb begin
    unique case (order_i)
      ORD_LINEAR: low_o = base_lo_i + beat_i;
      default:    low_o = base_lo_i ^ beat_i;
    endcase
  end

  // beat 0 is the base in either ordering
  always_comb begin
    assert (beat_i != '0 || low_o == base_lo_i);
  end
endmodule

// File: rtl/burst_seq.sv
module burst_seq
  import burst_seq_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int BEATS  = 4
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      load_i,
  input  logic                      adv_i,
  input  logic                      mode_i,
  input  logic [ADDR_W-1:0]         addr_i,
  output logic [ADDR_W-1:0]         addr_o,
  output logic [$clog2(BEATS)-1:0]  beat_o
);
  localparam int BEAT_W = $clog2(BEATS);

  logic [ADDR_W-1:0] base_q;
  burst_order_e      order_q;
  logic [BEAT_W-1:0] beat;
  logic [BEAT_W-1:0] low;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q  <= '0;
      order_q <= ORD_INTLV;
    end else if (load_i) begin
      base_q  <= addr_i;
      order_q <= burst_order_e'(mode_i);
    end
  end

  burst_beat_ctr #(.BEAT_W(BEAT_W)) ctr_i (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (load_i),
    .inc_i (adv_i),
    .cnt_o (beat)
  );

  burst_low_gen #(.BEAT_W(BEAT_W)) gen_i (
    .order_i  (order_q),
    .base_lo_i(base_q[BEAT_W-1:0]),
    .beat_i   (beat),
    .low_o    (low)
  );

  assign addr_o = {base_q[ADDR_W-1:BEAT_W], low};
  assign beat_o = beat;

  p_load_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (addr_o == $past(addr_i) && beat_o == '0));
  p_upper_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(addr_o[ADDR_W-1:BEAT_W]));
  p_idle_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !adv_i) |=> ($stable(addr_o) && $stable(beat_o)));
  p_step_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && adv_i) |=> beat_o == BEAT_W'($past(beat_o) + 1'b1));
  p_mode_latched_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(order_q));
endmodule

// File: tb/burst_seq_tb_top.sv
module burst_seq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W     = 20;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              load = 1'b0, adv = 1'b0, mode = 1'b0;
  logic [ADDR_W-1:0] addr_in = '0;
  logic [ADDR_W-1:0] addr_out;
  logic [1:0]        beat_out;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  logic [ADDR_W-1:0] e_base = '0;
  logic              e_lin = 1'b0;
  int                e_k = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  burst_seq #(.ADDR_W(ADDR_W), .BEATS(4)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .load_i(load), .adv_i(adv), .mode_i(mode),
    .addr_i(addr_in), .addr_o(addr_out), .beat_o(beat_out)
  );

  function automatic logic [ADDR_W-1:0] exp_addr();
    logic [1:0] lo;
    lo = e_lin ? 2'((int'(e_base[1:0]) + e_k) % 4) : (e_base[1:0] ^ 2'(e_k % 4));
    return {e_base[ADDR_W-1:2], lo};
  endfunction

  task automatic chk(input string req);
    n_chk++;
    if (addr_out !== exp_addr() || beat_out !== 2'(e_k % 4)) begin
      n_fail++;
      $display("FAIL %s: addr=%h beat=%0d expected addr=%h beat=%0d",
               req, addr_out, beat_out, exp_addr(), e_k % 4);
    end
  endtask

  // drive at negedge, sample a quarter period after the next posedge
  task automatic cyc(input logic ld, input logic av, input logic md,
                     input logic [ADDR_W-1:0] a, input string req);
    @(negedge clk);
    load = ld; adv = av; mode = md; addr_in = a;
    @(posedge clk);
    if (ld) begin e_base = a; e_lin = md; e_k = 0; end
    else if (av) e_k++;
    #(CLK_PERIOD/4);
    chk(req);
  endtask

  initial begin
    #(CLK_PERIOD*100000);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [ADDR_W-1:0] a;
    repeat (2) @(posedge clk);
    #1; chk("R1 in reset");
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #(CLK_PERIOD/4); chk("R1 after reset");

    // R3 R4 R5 R6: all bases, both orderings, past the wrap
    for (int m = 0; m < 2; m++) begin
      for (int b = 0; b < 4; b++) begin
        a = {18'(32'h2A5C3 ^ (b * 32'h1111) ^ (m * 32'h3F00)), 2'(b)};
        cyc(1, 0, m[0], a, "R2 load");
        for (int s = 0; s < 7; s++)
          cyc(0, 1, ~m[0], '0, m ? "R3 R5 R6 linear step" : "R4 R5 R6 interleaved step");
      end
    end

    // R7: mode flips mid-burst with no effect
    cyc(1, 0, 1'b0, 20'h81232, "R2 load");
    cyc(0, 1, 1'b1, '0, "R7 mode change ignored");
    cyc(0, 1, 1'b0, '0, "R7 mode change ignored");
    cyc(0, 1, 1'b1, '0, "R7 mode change ignored");

    // R9: idle holds
    cyc(0, 0, 1'b1, 20'hFFFFF, "R9 hold");
    cyc(0, 0, 1'b0, 20'h00000, "R9 hold");

    // R10: load wins over advance
    cyc(0, 1, 1'b0, '0, "R5 step");
    cyc(1, 1, 1'b1, 20'h5A5A7, "R10 load priority");
    cyc(0, 1, 1'b0, '0, "R3 linear after priority load");

    // R8: load every cycle
    for (int i = 0; i < 8; i++)
      cyc(1, i[0], i[1], 20'((i * 32'h1357B) ^ 32'hC0DE1), "R8 single access");

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule